// File: doc/BRIEF.md
# Split-Address Chip Identification Reader

This block runs a fixed identification sequence against a target that takes register-pointer writes on one 7-bit bus address and serves register data on another. It does not drive the bus wires itself. It sits above a byte-level I2C controller and issues one command at a time: START, WRITE of a byte, READ of a byte, or STOP. For each command it waits for a response that carries the acknowledge status and, for reads, the received byte.

Each register access takes two complete transactions, each closed by its own STOP. The first sends the pointer to the command address. The second reads one byte from the data address. The block reads three registers: two identification bytes and a version byte. From the version byte it derives a revision number and a memory size in kilobytes, and the size table depends on the revision. It also checks the first identification byte against an expected value.

When the sequence ends, the block presents the raw bytes, the decoded results and an error code together, with a single-cycle done strobe.

Top module: `chipid_reader`

## Requirements
- R1: The pointer transaction for register n is the command sequence START, WRITE 0xB4 (address 0x5A shifted left, write bit 0), WRITE n, STOP.
- R2: The data transaction is START, WRITE 0x6B (address 0x35 shifted left, read bit 1), READ, STOP. Every START after the first is preceded by a STOP, so no repeated start occurs.
- R3: Registers are accessed in the order 0, 1, 2. The bytes read appear on `id1`, `id2` and `ver_byte` respectively.
- R4: Command handshake. While `cmd_valid` is high and `cmd_ready` is low, the op and data hold steady. A new command is not offered until `rsp_valid` has answered the previous one. No command is offered while `busy` is low.
- R5: A NACK on any WRITE ends the sequence. The next command is a STOP, and after it the block issues nothing further. It then reports `err_code` 1 with `version` and `size_kb` at 0. Bytes not yet read read as 0.
- R6: `version` is `ver_byte` AND 0x07, so bit 3 of the version byte has no effect.
- R7: For versions 0 to 2, the size code `ver_byte[7:4]` maps 0 to 128, 4 to 192 and 8 to 256. Any other code gives `err_code` 4.
- R8: For version 3, the size code maps 0 to 128, 2 to 192, 4 to 256, 6 to 384 and 8 to 512. Any other code gives `err_code` 5.
- R9: Versions 4 to 7 give `err_code` 3. Any decode error (codes 3, 4 or 5) forces `size_kb` to 0.
- R10: If `id1` is not 0x83 after all transfers succeed, `err_code` is 2, which overrides codes 3 to 5. `size_kb` still follows R7 to R9. When nothing is wrong, `err_code` is 0.
- R11: `start` is taken only while `busy` is low and is otherwise ignored. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R12: After reset, `busy`, `done` and `cmd_valid` are low, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken while idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| cmd_valid | output | 1 | Command offered to the byte controller |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | output | 8 | Byte to write |
| rsp_valid | input | 1 | Controller finished the command |
| rsp_ack | input | 1 | Target acknowledged (checked on WRITE only) |
| rsp_data | input | 8 | Byte received on READ |
| id1 | output | 8 | First identification byte |
| id2 | output | 8 | Second identification byte |
| ver_byte | output | 8 | Raw version byte |
| version | output | 3 | Decoded revision |
| size_kb | output | 10 | Decoded memory size in KB |
| err_code | output | 3 | 0 ok, 1 bus, 2 ID, 3 revision, 4 early size, 5 late size |

## Verification
The assertions assume the controller follows the handshake. It raises `rsp_valid` only for a command it has already accepted, raises it once per command, and never raises `cmd_ready` and `rsp_valid` in the same exchange. The bench's responder model keeps to these rules. It accepts a command with a one-cycle ready pulse and answers after a fixed latency with a one-cycle response. It injects NACKs only on WRITE commands, at a chosen position in the stream, so the abort path is exercised for both address phases and for the offset byte.

// File: rtl/chipid_pkg.sv
package chipid_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_BUS       = 3'd1,
    E_ID        = 3'd2,
    E_REV       = 3'd3,
    E_SIZE_OLD  = 3'd4,
    E_SIZE_NEW  = 3'd5
  } id_err_e;

endpackage

// File: rtl/chipid_seq.sv
module chipid_seq
  import chipid_pkg::*;
#(
  parameter logic [6:0] PTR_ADDR = 7'h5A,
  parameter logic [6:0] DAT_ADDR = 7'h35,
  parameter int         NREG     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output bus_op_e           cmd_op,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data,
  output logic [NREG*8-1:0] rd_bytes,
  output logic              fin,
  output logic              bus_fail
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);
  localparam logic [2:0] STEP_READ = 3'd6;
  localparam logic [2:0] STEP_STOP = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} st_e;

  st_e              st_q;
  logic [2:0]       step_q;
  logic [IDX_W-1:0] idx_q;
  logic             abort_q;
  logic [7:0]       byte_q [NREG];

  // command table per step within one register access
  always_comb begin
    cmd_op   = OP_STOP;
    cmd_data = 8'h00;
    case (step_q)
      3'd0, 3'd4: cmd_op = OP_START;
      3'd1: begin cmd_op = OP_WRITE; cmd_data = {PTR_ADDR, 1'b0}; end
      3'd2: begin cmd_op = OP_WRITE; cmd_data = 8'(idx_q); end
      3'd5: begin cmd_op = OP_WRITE; cmd_data = {DAT_ADDR, 1'b1}; end
      3'd6: cmd_op = OP_READ;
      default: cmd_op = OP_STOP;
    endcase
  end

  assign cmd_valid = (st_q == S_ISSUE);
  assign busy      = (st_q != S_IDLE);
  assign fin       = (st_q == S_FIN);
  assign bus_fail  = abort_q;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_pack
      assign rd_bytes[g*8 +: 8] = byte_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      step_q  <= 3'd0;
      idx_q   <= '0;
      abort_q <= 1'b0;
      for (int i = 0; i < NREG; i++) byte_q[i] <= 8'h00;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q    <= S_ISSUE;
          step_q  <= 3'd0;
          idx_q   <= '0;
          abort_q <= 1'b0;
          for (int i = 0; i < NREG; i++) byte_q[i] <= 8'h00;
        end
        S_ISSUE: if (cmd_ready) st_q <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (cmd_op == OP_WRITE && !rsp_ack) begin
            abort_q <= 1'b1;
            step_q  <= STEP_STOP;
            st_q    <= S_ISSUE;
          end else if (step_q == STEP_READ) begin
            byte_q[idx_q] <= rsp_data;
            step_q        <= STEP_STOP;
            st_q          <= S_ISSUE;
          end else if (step_q == STEP_STOP) begin
            if (abort_q || idx_q == LAST_IDX) begin
              st_q <= S_FIN;
            end else begin
              idx_q  <= idx_q + 1'b1;
              step_q <= 3'd0;
              st_q   <= S_ISSUE;
            end
          end else begin
            step_q <= step_q + 3'd1;
            st_q   <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data)); // R4

  AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT) && rsp_valid && (cmd_op == OP_WRITE) && !rsp_ack
      |=> cmd_valid && (cmd_op == OP_STOP)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid); // R4

endmodule

// File: rtl/chipid_decode.sv
module chipid_decode
  import chipid_pkg::*;
#(
  parameter logic [7:0] ID_EXPECT = 8'h83,
  parameter int         SIZE_W    = 10
) (
  input  logic [7:0]        id_first,
  input  logic [7:0]        ver_raw,
  input  logic              bus_fail,
  output logic [2:0]        rev,
  output logic [SIZE_W-1:0] kb,
  output id_err_e           err
);

  localparam logic [2:0] LATE_REV = 3'd3;

  logic [2:0]  rev_raw;
  logic [3:0]  code;
  id_err_e     dec_err;
  logic [SIZE_W-1:0] kb_dec;

  assign rev_raw = ver_raw[2:0];
  assign code    = ver_raw[7:4];

  always_comb begin
    kb_dec  = '0;
    dec_err = E_NONE;
    if (rev_raw < LATE_REV) begin
      case (code)
        4'd0: kb_dec = SIZE_W'(128);
        4'd4: kb_dec = SIZE_W'(192);
        4'd8: kb_dec = SIZE_W'(256);
        default: dec_err = E_SIZE_OLD;
      endcase
    end else if (rev_raw == LATE_REV) begin
      case (code)
        4'd0: kb_dec = SIZE_W'(128);
        4'd2: kb_dec = SIZE_W'(192);
        4'd4: kb_dec = SIZE_W'(256);
        4'd6: kb_dec = SIZE_W'(384);
        4'd8: kb_dec = SIZE_W'(512);
        default: dec_err = E_SIZE_NEW;
      endcase
    end else begin
      dec_err = E_REV;
    end

    if (bus_fail) begin
      rev = 3'd0;
      kb  = '0;
      err = E_BUS;
    end else begin
      rev = rev_raw;
      kb  = kb_dec;
      err = (id_first != ID_EXPECT) ? E_ID : dec_err;
    end
  end

endmodule

// File: rtl/chipid_reader.sv
module chipid_reader
  import chipid_pkg::*;
#(
  parameter logic [6:0] PTR_ADDR  = 7'h5A,
  parameter logic [6:0] DAT_ADDR  = 7'h35,
  parameter logic [7:0] ID_EXPECT = 8'h83,
  parameter int         SIZE_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data,
  output logic [7:0]        id1,
  output logic [7:0]        id2,
  output logic [7:0]        ver_byte,
  output logic [2:0]        version,
  output logic [SIZE_W-1:0] size_kb,
  output logic [2:0]        err_code
);

  localparam int NREG = 3;

  bus_op_e           op_w;
  logic [NREG*8-1:0] bytes_w;
  logic              fin_w;
  logic              fail_w;
  logic [2:0]        rev_w;
  logic [SIZE_W-1:0] kb_w;
  id_err_e           err_w;

  chipid_seq #(
    .PTR_ADDR (PTR_ADDR),
    .DAT_ADDR (DAT_ADDR),
    .NREG     (NREG)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (op_w),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_data  (rsp_data),
    .rd_bytes  (bytes_w),
    .fin       (fin_w),
    .bus_fail  (fail_w)
  );

  assign cmd_op = op_w;

  chipid_decode #(
    .ID_EXPECT (ID_EXPECT),
    .SIZE_W    (SIZE_W)
  ) u_dec (
    .id_first (bytes_w[7:0]),
    .ver_raw  (bytes_w[23:16]),
    .bus_fail (fail_w),
    .rev      (rev_w),
    .kb       (kb_w),
    .err      (err_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      id1      <= 8'h00;
      id2      <= 8'h00;
      ver_byte <= 8'h00;
      version  <= 3'd0;
      size_kb  <= '0;
      err_code <= 3'd0;
    end else begin
      done <= fin_w;
      if (fin_w) begin
        id1      <= bytes_w[7:0];
        id2      <= bytes_w[15:8];
        ver_byte <= bytes_w[23:16];
        version  <= rev_w;
        size_kb  <= kb_w;
        err_code <= err_w;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11

  AST_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    done && (err_code == 3'd3 || err_code == 3'd4 || err_code == 3'd5)
      |-> size_kb == '0); // R9

  AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done && (err_code == 3'd1) |-> (size_kb == '0) && (version == 3'd0)); // R5

endmodule

// File: tb/test_chipid_reader.sv
module test_chipid_reader;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       busy, done, cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0;
  logic       rsp_ack = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic [7:0] id1, id2, ver_byte;
  logic [2:0] version, err_code;
  logic [9:0] size_kb;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipid_reader i_chipid_reader (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_data(rsp_data), .id1(id1), .id2(id2), .ver_byte(ver_byte),
    .version(version), .size_kb(size_kb), .err_code(err_code)
  );

  // main counters (initial block) and responder counters (always block)
  int checks = 0, fails = 0;
  int r_checks = 0, r_fails = 0;
  bit finished = 0;

  // behavioural target and expected command stream
  logic [7:0] tgt [3];
  int nack_at = 0;
  int exp_q [$];
  int rstate = 0, lat = 0, wr_cnt = 0, ptr = 0;
  bit ptr_next = 0;
  bit running = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // controller + target model, all driving at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      rstate <= 0;
      cmd_ready <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      r_checks++;
      if (cmd_valid && !running) begin
        r_fails++;
        $display("FAIL R4 actual=%0d expected=%0d (command while idle)", 1, 0);
      end
      case (rstate)
        0: if (cmd_valid) begin
          r_checks++;
          if (exp_q.size() == 0) begin
            r_fails++;
            $display("FAIL R1/R2 actual=%0d expected=%0d (extra command)",
                     cmd_op * 256 + cmd_data, -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            if (e != cmd_op * 256 + cmd_data) begin
              r_fails++;
              $display("FAIL R1/R2/R3 actual=%0d expected=%0d",
                       cmd_op * 256 + cmd_data, e);
            end
          end
          rsp_ack  <= 1'b1;
          rsp_data <= 8'h00;
          if (cmd_op == 2'd1) begin
            wr_cnt = wr_cnt + 1;
            if (wr_cnt == nack_at) rsp_ack <= 1'b0;
            else if (cmd_data == 8'hB4) ptr_next = 1;
            else if (ptr_next) begin ptr = cmd_data; ptr_next = 0; end
          end else if (cmd_op == 2'd2) begin
            rsp_data <= (ptr < 3) ? tgt[ptr] : 8'hEE;
          end
          cmd_ready <= 1'b1;
          rstate <= 1;
        end
        1: begin cmd_ready <= 1'b0; lat <= 2; rstate <= 2; end
        2: if (lat == 0) begin rsp_valid <= 1'b1; rstate <= 3; end
           else lat <= lat - 1;
        default: begin rsp_valid <= 1'b0; rstate <= 0; end
      endcase
    end
  end

  function automatic void build_expect(input int nk);
    int w;
    w = 0;
    exp_q.delete();
    for (int r = 0; r < 3; r++) begin
      int seqv [8];
      seqv = '{0, 256 + 8'hB4, 256 + r, 3 * 256, 0, 256 + 8'h6B, 2 * 256, 3 * 256};
      for (int k = 0; k < 8; k++) begin
        exp_q.push_back(seqv[k]);
        if (seqv[k] / 256 == 1) begin
          w++;
          if (w == nk) begin
            exp_q.push_back(3 * 256);
            return;
          end
        end
      end
    end
  endfunction

  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] v,
                     input int nk, input bit poke, input string tag);
    int e_id1, e_id2, e_ver, e_rev, e_kb, e_err, code, wait_cyc, ndone;
    tgt[0] = a; tgt[1] = b; tgt[2] = v;
    nack_at = nk; wr_cnt = 0; ptr = 0; ptr_next = 0;
    build_expect(nk);
    // expected results
    e_id1 = a; e_id2 = b; e_ver = v;
    if (nk > 0) begin
      int bad_reg;
      bad_reg = (nk - 1) / 3;
      if (bad_reg <= 0) e_id1 = 0;
      if (bad_reg <= 1) e_id2 = 0;
      e_ver = 0; e_rev = 0; e_kb = 0; e_err = 1;
    end else begin
      e_rev = v % 8;
      code = v / 16;
      e_kb = 0; e_err = 0;
      if (e_rev < 3) begin
        if (code == 0) e_kb = 128; else if (code == 4) e_kb = 192;
        else if (code == 8) e_kb = 256; else e_err = 4;
      end else if (e_rev == 3) begin
        if (code == 0) e_kb = 128; else if (code == 2) e_kb = 192;
        else if (code == 4) e_kb = 256; else if (code == 6) e_kb = 384;
        else if (code == 8) e_kb = 512; else e_err = 5;
      end else e_err = 3;
      if (a != 8'h83) e_err = 2;
    end
    @(negedge clk);
    running = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R11 busy after start ", tag}, busy, 1);
    wait_cyc = 0; ndone = 0;
    while (!done && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
      if (poke && wait_cyc == 7) start = 1'b1;
      if (poke && wait_cyc == 9) start = 1'b0;
    end
    chk(done == 1'b1, {"R11 done seen ", tag}, done, 1);
    chk(busy == 1'b0, {"R11 busy low with done ", tag}, busy, 0);
    chk(id1 == e_id1[7:0], {"R3 id1 ", tag}, id1, e_id1);
    chk(id2 == e_id2[7:0], {"R3 id2 ", tag}, id2, e_id2);
    chk(ver_byte == e_ver[7:0], {"R3 ver_byte ", tag}, ver_byte, e_ver);
    chk(version == e_rev[2:0], {"R6 version ", tag}, version, e_rev);
    chk(size_kb == e_kb[9:0], {"R7/R8/R9 size ", tag}, size_kb, e_kb);
    chk(err_code == e_err[2:0], {"R5/R10 err ", tag}, err_code, e_err);
    @(negedge clk);
    chk(done == 1'b0, {"R11 done one cycle ", tag}, done, 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 0, {"R11 no second run ", tag}, ndone, 0);
    chk(exp_q.size() == 0, {"R1/R2 stream complete ", tag}, exp_q.size(), 0);
    chk(cmd_valid == 1'b0, {"R5 quiet after end ", tag}, cmd_valid, 0);
    running = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0 && done == 0 && cmd_valid == 0, "R12 control low", busy + done + cmd_valid, 0);
    chk(size_kb == 0 && err_code == 0 && id1 == 0 && version == 0, "R12 results zero",
        size_kb + err_code + id1 + version, 0);

    run(8'h83, 8'h20, 8'h42, 0, 0, "early 192");      // R7
    run(8'h83, 8'h20, 8'h00, 0, 0, "early 128");      // R7
    run(8'h83, 8'h21, 8'h81, 0, 0, "early 256");      // R7
    run(8'h83, 8'h20, 8'h22, 0, 0, "early bad");      // R7 R9
    run(8'h83, 8'h20, 8'h63, 0, 0, "late 384");       // R8
    run(8'h83, 8'h20, 8'h83, 0, 0, "late 512");       // R8
    run(8'h83, 8'h20, 8'h23, 0, 0, "late 192");       // R8
    run(8'h83, 8'h20, 8'h33, 0, 0, "late bad");       // R8 R9
    run(8'h83, 8'h20, 8'h05, 0, 0, "rev unknown");    // R9
    run(8'h83, 8'h20, 8'h4A, 0, 0, "bit3 ignored");   // R6
    run(8'h84, 8'h20, 8'h42, 0, 0, "id mismatch");    // R10
    run(8'h84, 8'h20, 8'h07, 0, 0, "id over rev");    // R10
    run(8'h83, 8'h20, 8'h42, 1, 0, "nack ptr addr");  // R5
    run(8'h83, 8'h20, 8'h42, 2, 0, "nack offset");    // R5
    run(8'h83, 8'h20, 8'h42, 6, 0, "nack data addr"); // R5
    run(8'h83, 8'h55, 8'h42, 9, 0, "nack last addr"); // R5
    run(8'h83, 8'h20, 8'h63, 0, 1, "start ignored");  // R11

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + r_checks, fails + r_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + r_checks + 1, fails + r_fails + 1);
      $finish;
    end
  end

endmodule